// File: doc/BRIEF.md
# I2C Serial EEPROM Slave Controller

This block is the two-wire serial front end of a byte-addressed non-volatile memory of 8192 bytes. A synchronous RAM inside the block stands in for the storage array. SCL and SDA are sampled in a fast system clock domain. SDA is driven open-drain: the block only ever pulls the line low. The block detects START and STOP conditions and answers only when the device select code matches. It then takes a two-byte memory address and serves byte writes, short page writes, random reads and sequential reads.

A write transfer ends with the master's STOP after the slave's acknowledge. That STOP launches a self-timed programming interval, which is modelled by a cycle counter and shown on a busy output. During that interval the block refuses its device select code. A master finds out when the write has finished by polling the bus until the code is acknowledged again. A read transfer ends when the master answers a byte with NoAck and then issues STOP.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: After reset the block releases SDA (`sda_pull` = 0) and `prog_busy` is 0.
- R2: A device select byte whose four most significant bits are 1010 is acknowledged by pulling SDA low during the 9th clock. Any other upper nibble gets no acknowledge, and the block ignores the bus until the next START.
- R3: After a select byte with bit 0 = 0 (write), the block acknowledges two address bytes, sent most significant first. Only the lower 13 bits of the 16 received bits form the address, so the upper three bits have no effect.
- R4: Each data byte that follows the address is acknowledged and stored at the current address.
- R5: Successive data bytes of one write advance only address bits [1:0]. A fifth or later byte wraps to the start of the same aligned 4-byte page and overwrites it.
- R6: A STOP that ends a transfer in which at least one data byte was written raises `prog_busy` for exactly PROG_CYC clock cycles. A STOP after only an address phase leaves `prog_busy` at 0.
- R7: While `prog_busy` is 1, a matching device select byte is not acknowledged. Once `prog_busy` has returned to 0, the same byte is acknowledged.
- R8: After a dummy write of the address, a repeated START and a select byte with bit 0 = 1 (read), the block returns the byte stored at that address, most significant bit first.
- R9: Each byte that the master acknowledges is followed by the byte at the next address. The address wraps from 8191 to 0.
- R10: When the master answers a read byte with NoAck, the block releases SDA and drives nothing more until the next START. It also leaves SDA released while the master gives its answer after each read byte.
- R11: The block changes its SDA drive only while SCL is low. START is a falling SDA edge while SCL is high, and STOP is a rising SDA edge while SCL is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; it must run much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Serial clock line as seen on the bus |
| sda_in | input | 1 | Serial data line as seen on the bus |
| sda_pull | output | 1 | 1 pulls SDA low; 0 releases it |
| prog_busy | output | 1 | 1 while the self-timed programming interval runs |

## Verification
Two things can meet in one decision: the programming interval ending and an acknowledge polling attempt. When the 8th bit of a select byte has been taken in, the controller reads `prog_busy` in the same cycle that decides whether to acknowledge. The bench provokes this by polling right after each write's STOP and then again and again until an acknowledge comes back. It checks that every attempt made while busy is refused, and that the busy interval lasts exactly PROG_CYC cycles. A second overlap is the RAM write of a data byte and the address step within the page, which happen together. Page writes longer than four bytes are read back against a bench model to judge it.

// File: rtl/eep_pkg.sv
// Package eep_pkg
// Shared types and constants for the serial EEPROM slave.
// Assumes: the device type code sits in the upper nibble of the select byte.
package eep_pkg;
    localparam logic [3:0] DEV_TYPE = 4'b1010;

    typedef enum logic [2:0] {
        S_IDLE,   // not addressed, waiting for START
        S_DEV,    // shifting in the device select byte
        S_AHI,    // shifting in the address high byte
        S_ALO,    // shifting in the address low byte
        S_WR,     // shifting in write data bytes
        S_RD      // shifting out read data bytes
    } eep_state_t;
endpackage

// File: rtl/eep_sync.sv
// Module eep_sync
// Multi-stage synchronizer for one asynchronous bus line into clk.
// Assumes: the line idles high, so the stages reset to 1.
module eep_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] chain;

    // Shift the raw line through the synchronizing stages.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d_in};
    end

    assign q_out = chain[STAGES-1];
endmodule

// File: rtl/eep_cond_detect.sv
// Module eep_cond_detect
// Finds SCL edges and START/STOP conditions on the synchronized lines.
// Assumes: inputs are already synchronized to clk; each output is a one-cycle pulse.
module eep_cond_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_d, sda_d;

    // Keep the previous sample of both lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    assign scl_rise  =  scl_s & ~scl_d;
    assign scl_fall  = ~scl_s &  scl_d;
    assign start_det =  scl_s &  scl_d &  sda_d & ~sda_s;
    assign stop_det  =  scl_s &  scl_d & ~sda_d &  sda_s;
endmodule

// File: rtl/eep_ram.sv
// Module eep_ram
// Single-port synchronous RAM standing in for the non-volatile array.
// Assumes: one access per cycle; read data appears one cycle after the address.
module eep_ram #(
    parameter int AW = 13,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Write on request, register the read every cycle.
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        rdata <= mem[addr];
    end
endmodule

// File: rtl/eep_prog_timer.sv
// Module eep_prog_timer
// Models the self-timed programming interval as a down counter.
// Assumes: go is a one-cycle pulse; busy stays high for exactly CYC cycles.
module eep_prog_timer #(
    parameter int CYC = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic busy
);
    localparam int CW = $clog2(CYC + 1);

    logic [CW-1:0] remain;

    // Load the interval on go, count down to zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)           remain <= '0;
        else if (go)          remain <= CW'(CYC);
        else if (remain != 0) remain <= remain - 1'b1;
    end

    assign busy = (remain != 0);
endmodule

// File: rtl/i2c_eeprom_slave.sv
// Module i2c_eeprom_slave
// Two-wire serial slave for a byte-addressed memory: select match, two-byte
// address, page-limited writes, random and sequential reads, busy polling.
// Assumes: clk runs well above 8x the SCL rate; ADDR_W <= 16; SDA is open-drain
// and sda_pull = 1 means the line is pulled low.
module i2c_eeprom_slave
    import eep_pkg::*;
#(
    parameter int ADDR_W      = 13,
    parameter int PAGE_AW     = 2,
    parameter int PROG_CYC    = 5000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_pull,
    output logic prog_busy
);
    localparam int BYTE_BITS = 8;

    logic scl_s, sda_s;
    logic scl_rise, scl_fall, start_det, stop_det;

    eep_state_t         state, after_ack;
    logic               in_ack;
    logic [3:0]         bit_cnt;
    logic [7:0]         rx_sh, tx_sh, addr_hi;
    logic [ADDR_W-1:0]  addr, wr_addr, ram_addr;
    logic               wr_pend, prog_go, ram_we;
    logic [7:0]         ram_wdata, ram_q;

    eep_sync #(.STAGES(SYNC_STAGES)) u_sync_scl (
        .clk(clk), .rst_n(rst_n), .d_in(scl_in), .q_out(scl_s)
    );
    eep_sync #(.STAGES(SYNC_STAGES)) u_sync_sda (
        .clk(clk), .rst_n(rst_n), .d_in(sda_in), .q_out(sda_s)
    );

    eep_cond_detect u_det (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    assign ram_addr = ram_we ? wr_addr : addr;

    eep_ram #(.AW(ADDR_W), .DW(8)) u_ram (
        .clk(clk), .we(ram_we), .addr(ram_addr), .wdata(ram_wdata), .rdata(ram_q)
    );

    eep_prog_timer #(.CYC(PROG_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .go(prog_go), .busy(prog_busy)
    );

    // Bus protocol engine: byte shifting, acknowledge, address and data flow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            after_ack <= S_IDLE;
            in_ack    <= 1'b0;
            bit_cnt   <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            addr_hi   <= '0;
            addr      <= '0;
            wr_addr   <= '0;
            wr_pend   <= 1'b0;
            prog_go   <= 1'b0;
            ram_we    <= 1'b0;
            ram_wdata <= '0;
            sda_pull  <= 1'b0;
        end else begin
            ram_we  <= 1'b0;
            prog_go <= 1'b0;
            if (start_det) begin
                state    <= S_DEV;
                bit_cnt  <= '0;
                in_ack   <= 1'b0;
                sda_pull <= 1'b0;
            end else if (stop_det) begin
                state    <= S_IDLE;
                in_ack   <= 1'b0;
                sda_pull <= 1'b0;
                if (wr_pend) begin
                    prog_go <= 1'b1;
                    wr_pend <= 1'b0;
                end
            end else begin
                case (state)
                    S_DEV, S_AHI, S_ALO, S_WR: begin
                        if (!in_ack) begin
                            if (scl_rise) begin
                                rx_sh   <= {rx_sh[6:0], sda_s};
                                bit_cnt <= bit_cnt + 1'b1;
                            end else if (scl_fall && bit_cnt == 4'(BYTE_BITS)) begin
                                in_ack   <= 1'b1;
                                sda_pull <= 1'b1;
                                case (state)
                                    S_DEV: begin
                                        if (rx_sh[7:4] == DEV_TYPE && !prog_busy) begin
                                            after_ack <= rx_sh[0] ? S_RD : S_AHI;
                                        end else begin
                                            state    <= S_IDLE;
                                            in_ack   <= 1'b0;
                                            sda_pull <= 1'b0;
                                        end
                                    end
                                    S_AHI: begin
                                        addr_hi   <= rx_sh;
                                        after_ack <= S_ALO;
                                    end
                                    S_ALO: begin
                                        addr      <= ADDR_W'({addr_hi, rx_sh});
                                        after_ack <= S_WR;
                                    end
                                    default: begin
                                        ram_we    <= 1'b1;
                                        ram_wdata <= rx_sh;
                                        wr_addr   <= addr;
                                        wr_pend   <= 1'b1;
                                        addr      <= {addr[ADDR_W-1:PAGE_AW],
                                                      addr[PAGE_AW-1:0] + 1'b1};
                                        after_ack <= S_WR;
                                    end
                                endcase
                            end
                        end else if (scl_fall) begin
                            in_ack   <= 1'b0;
                            sda_pull <= 1'b0;
                            bit_cnt  <= '0;
                            state    <= after_ack;
                            if (after_ack == S_RD) begin
                                tx_sh    <= ram_q;
                                sda_pull <= ~ram_q[7];
                                addr     <= addr + 1'b1;
                            end
                        end
                    end
                    S_RD: begin
                        if (!in_ack) begin
                            if (scl_rise) begin
                                bit_cnt <= bit_cnt + 1'b1;
                            end else if (scl_fall) begin
                                if (bit_cnt == 4'(BYTE_BITS)) begin
                                    sda_pull <= 1'b0;
                                    in_ack   <= 1'b1;
                                end else begin
                                    tx_sh    <= {tx_sh[6:0], 1'b0};
                                    sda_pull <= ~tx_sh[6];
                                end
                            end
                        end else begin
                            if (scl_rise && sda_s) begin
                                state  <= S_IDLE;
                                in_ack <= 1'b0;
                            end else if (scl_fall) begin
                                in_ack   <= 1'b0;
                                bit_cnt  <= '0;
                                tx_sh    <= ram_q;
                                sda_pull <= ~ram_q[7];
                                addr     <= addr + 1'b1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // The drive on SDA moves only with SCL low or right after a bus condition.
    assert_sda_moves_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pull != $past(sda_pull)) |-> (!scl_s || $past(start_det || stop_det)));

    // The programming interval starts only from a STOP two cycles earlier.
    assert_busy_from_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_busy) |-> $past(stop_det, 2));

    // No acknowledge of the select byte while programming runs.
    assert_no_ack_while_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DEV && prog_busy) |-> !sda_pull);

    // Within a write burst the page part of the address stays put.
    assert_page_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WR && $past(state) == S_WR) |-> $stable(addr[ADDR_W-1:PAGE_AW]));

    // SDA is left to the master while it answers a read byte.
    assert_master_ack_free_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RD && in_ack) |-> !sda_pull);
endmodule

// File: tb/i2c_eeprom_slave_test.sv
module i2c_eeprom_slave_test;
    localparam int PROG = 1000;
    localparam int Q    = 8;
    localparam int AW   = 13;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_pull, prog_busy;
    logic sda_line;

    int checks = 0;
    int fails  = 0;
    int busy_len = 0;
    int r11_viol = 0;
    bit done = 1'b0;
    logic prev_pull = 1'b0;
    logic [7:0] mdl [1 << AW];

    always #4 clk = ~clk;

    assign sda_line = sda_m & ~sda_pull;

    i2c_eeprom_slave #(.PROG_CYC(PROG)) uut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
        .sda_pull(sda_pull), .prog_busy(prog_busy)
    );

    always @(posedge clk) begin
        if (prog_busy) busy_len <= busy_len + 1;
        if (rst_n && scl_m && (sda_pull != prev_pull)) r11_viol <= r11_viol + 1;
        prev_pull <= sda_pull;
    end

    task automatic chk(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q);
            scl_m = 1'b1; tick(2 * Q);
            scl_m = 1'b0; tick(Q);
        end
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        ack = ~sda_line;
        tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; tick(Q);
            scl_m = 1'b1; tick(Q);
            b[i] = sda_line;
            tick(Q);
            scl_m = 1'b0; tick(Q);
        end
        sda_m = ~mack; tick(Q);
        scl_m = 1'b1; tick(2 * Q);
        scl_m = 1'b0; tick(Q);
    endtask

    function automatic logic [AW-1:0] page_step(input logic [AW-1:0] a, input int k);
        return {a[AW-1:2], 2'(a[1:0] + 2'(k))};
    endfunction

    // Address phase after a write select; returns 1 if all three were acked.
    task automatic addr_phase(input logic [15:0] a, output bit ok);
        bit a0, a1, a2;
        bus_start();
        send_byte(8'hA0, a0);
        send_byte(a[15:8], a1);
        send_byte(a[7:0], a2);
        ok = a0 & a1 & a2;
    endtask

    task automatic wait_ready();
        bit ak;
        for (int n = 0; n < 40; n++) begin
            bus_start();
            send_byte(8'hA0, ak);
            bus_stop();
            if (ak) break;
            tick(40);
        end
    endtask

    task automatic write_seq(input logic [15:0] a, input logic [7:0] d[], input string req);
        bit ok, ak;
        addr_phase(a, ok);
        chk(ok, "R3", 16'(ok), 16'd1);
        for (int k = 0; k < d.size(); k++) begin
            send_byte(d[k], ak);
            chk(ak, req, 16'(ak), 16'd1);
            mdl[page_step(a[AW-1:0], k)] = d[k];
        end
        bus_stop();
    endtask

    task automatic read_seq(input logic [15:0] a, input int n, input string req);
        bit ok, ak;
        logic [7:0] b;
        logic [AW-1:0] p;
        addr_phase(a, ok);
        bus_start();
        send_byte(8'hA1, ak);
        chk(ak, "R2", 16'(ak), 16'd1);
        p = a[AW-1:0];
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n - 1, b);
            chk(b === mdl[p], req, {8'h0, b}, {8'h0, mdl[p]});
            p = p + 1'b1;
        end
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        bit ak, ok;
        logic [7:0] b;
        logic [7:0] d[];
        int unsigned seed;
        seed = $urandom(32'd20240611);
        tick(5);
        rst_n = 1'b1;
        tick(3);
        // R1: reset state
        chk(sda_pull == 1'b0, "R1", 16'(sda_pull), 16'd0);
        chk(prog_busy == 1'b0, "R1", 16'(prog_busy), 16'd0);

        // R2: non-matching select codes get no acknowledge
        for (int k = 0; k < 4; k++) begin
            logic [7:0] sel;
            sel = 8'($urandom());
            if (sel[7:4] == 4'b1010) sel[7:4] = 4'b0101;
            bus_start();
            send_byte(sel, ak);
            chk(!ak, "R2", 16'(ak), 16'd0);
            send_byte(8'h00, ak);
            chk(!ak, "R2", 16'(ak), 16'd0);
            bus_stop();
        end

        // R4/R6/R7: byte write, busy length, refused poll
        d = new[1]; d[0] = 8'h5A;
        busy_len = 0;
        write_seq(16'h0123, d, "R4");
        tick(4);
        chk(prog_busy, "R6", 16'(prog_busy), 16'd1);
        bus_start();
        send_byte(8'hA0, ak);
        chk(!ak, "R7", 16'(ak), 16'd0);
        bus_stop();
        tick(PROG);
        chk(!prog_busy, "R6", 16'(prog_busy), 16'd0);
        chk(busy_len == PROG, "R6", 16'(busy_len), 16'(PROG));
        bus_start();
        send_byte(8'hA0, ak);
        chk(ak, "R7", 16'(ak), 16'd1);
        bus_stop();

        // R8: random read; R3: high address bits ignored
        read_seq(16'h0123, 1, "R8");
        read_seq(16'hE123, 1, "R3");

        // R6: address-only transfer starts no programming
        addr_phase(16'h0040, ok);
        bus_stop();
        tick(4);
        chk(!prog_busy, "R6", 16'(prog_busy), 16'd0);

        // R5: six bytes into one page wrap within it
        d = new[6];
        for (int k = 0; k < 6; k++) d[k] = 8'hD0 + 8'(k);
        write_seq(16'h0206, d, "R5");
        wait_ready();
        read_seq(16'h0204, 4, "R5");

        // R9: wrap of sequential read from the last address
        d = new[1]; d[0] = 8'hC3;
        write_seq(16'h1FFF, d, "R4");
        wait_ready();
        d = new[2]; d[0] = 8'h3C; d[1] = 8'h00;
        write_seq(16'h0000, d, "R4");
        wait_ready();
        read_seq(16'h1FFF, 3, "R9");

        // R10: after NoAck the slave stays silent
        addr_phase(16'h0000, ok);
        bus_start();
        send_byte(8'hA1, ak);
        recv_byte(1'b0, b);
        chk(b == 8'h3C, "R10", {8'h0, b}, 16'h003C);
        recv_byte(1'b0, b);
        chk(b == 8'hFF, "R10", {8'h0, b}, 16'h00FF);
        bus_stop();

        // Random page writes and sequential read-back
        for (int it = 0; it < 12; it++) begin
            logic [15:0] a;
            int len;
            a   = 16'($urandom());
            len = 1 + int'($urandom() % 4);
            d = new[len];
            for (int k = 0; k < len; k++) d[k] = 8'($urandom());
            write_seq(a, d, "R5");
            wait_ready();
            read_seq({3'b000, a[12:2], 2'b00}, 4, "R9");
        end

        // R11: drive only changed with SCL low
        chk(r11_viol == 0, "R11", 16'(r11_viol), 16'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule